// File: doc/BRIEF.md
# Burst Fill Sequencer with Error and Retry Handling

This block sits on the bus side of a cache line fill. When the cache asks for a line it starts a burst of four beats, raises a burst request while the first beat is in progress, and advances a beat index on every bus acknowledge. After the last beat it reports completion with a single-cycle pulse.

It also decides how a terminated bus cycle is treated. A bus error together with halt on the first beat is a retry: the block pulses a retry strobe, drops the burst request while halt stays high, and then restarts the burst from the first beat with the request raised again. The same pair on a later beat is never a retry, not even for a misaligned operand. It is split into a halt, during which the block reports a halted flag for as long as halt stays high, and a bus error, which is requested as soon as halt is released. A bus error without halt ends the burst at once and requests bus-error handling.

Top module: `burst_fill_ctrl`

## Requirements
- R1: After reset busy_o, burst_req_o, retry_o, halted_o, berr_req_o and fill_done_o are 0 and beat_o is 0.
- R2: fill_start_i while idle starts a burst at beat 0. burst_req_o is 1 only while beat 0 is in progress. beat_o rises by one on each ack_i. The fourth ack_i clears busy_o and raises fill_done_o for exactly one cycle.
- R3: berr_i and halt_i together on beat 0 raise retry_o for one cycle in the next cycle. burst_req_o drops, busy_o stays 1 and no bus-error request is made.
- R4: After a retry, the first cycle with halt_i low restarts the burst at beat 0 with burst_req_o at 1. The restarted burst then completes normally.
- R5: berr_i and halt_i together on beat 1, 2 or 3 never raise retry_o. They set halted_o in the next cycle.
- R6: halted_o stays 1 and berr_req_o stays 0 for as long as halt_i stays 1.
- R7: In the first cycle after halt_i is seen low while halted, halted_o is 0, berr_req_o is 1 for exactly one cycle and busy_o is 0.
- R8: berr_i without halt_i on any beat ends the burst. berr_req_o is 1 for one cycle in the next cycle, with no retry and no halt.
- R9: berr_i takes priority over ack_i in the same cycle: the beat is not counted and no fill_done_o pulse is given.
- R10: halt_i without berr_i during a beat has no effect. beat_o changes only on ack_i, and retry_o and halted_o stay 0.
- R11: fill_start_i while a burst is in progress has no effect on beat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_start_i | input | 1 | Request a line fill (sampled while idle) |
| ack_i | input | 1 | Normal termination of the current beat |
| berr_i | input | 1 | Bus error termination |
| halt_i | input | 1 | Halt input |
| burst_req_o | output | 1 | Burst request, high during beat 0 |
| busy_o | output | 1 | Burst in progress, including retry wait and halt |
| beat_o | output | 2 | Index of the current beat |
| fill_done_o | output | 1 | One-cycle pulse when the last beat completes |
| retry_o | output | 1 | One-cycle retry strobe |
| halted_o | output | 1 | Halted on a later-beat error |
| berr_req_o | output | 1 | One-cycle bus-error exception request |

## Verification
The bench sweeps every beat with a lone bus error and with error plus halt, and holds halt for one to three cycles. A design that decodes the beat wrongly would retry on a later beat or halt on the first beat. A design that releases early would raise the error request while halt is still high. A retry that keeps the old beat index would show a non-zero beat_o, or no burst request, when the burst restarts. Further cases cover an error arriving together with an acknowledge, a lone halt, and a start request during a burst. A design that counted the beat, stalled or restarted in those cases would show a wrong beat_o or a stray fill_done_o pulse.

// File: rtl/burst_fill_pkg.sv
package burst_fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT  = 2'd1,
    ST_RETRY = 2'd2,
    ST_HALT  = 2'd3
  } fill_state_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEATS = 4,
  localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [BW-1:0] beat_o,
  output logic          first_o,
  output logic          last_o
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  logic [BW-1:0] beat_q, beat_d;

  generate
    if ((1 << BW) == BEATS) begin : g_pow2
      always_comb beat_d = beat_q + 1'b1;
    end else begin : g_npow2
      always_comb beat_d = (beat_q == LAST_BEAT) ? '0 : beat_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beat_q <= '0;
    else if (clr_i) beat_q <= '0;
    else if (inc_i) beat_q <= beat_d;
  end

  assign beat_o  = beat_q;
  assign first_o = (beat_q == '0);
  assign last_o  = (beat_q == LAST_BEAT);

  // sequencer must close the burst instead of stepping past the last beat
  p_no_inc_past_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
  p_clr_inc_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && inc_i));
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_fill_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        ack_i,
  input  logic        berr_i,
  input  logic        halt_i,
  input  logic        first_i,
  input  logic        last_i,
  output fill_state_e state_o,
  output logic        ctr_clr_o,
  output logic        ctr_inc_o,
  output logic        retry_stb_o,
  output logic        halt_set_o,
  output logic        halt_clr_o,
  output logic        berr_stb_o,
  output logic        done_stb_o
);
  fill_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    ctr_clr_o   = 1'b0;
    ctr_inc_o   = 1'b0;
    retry_stb_o = 1'b0;
    halt_set_o  = 1'b0;
    halt_clr_o  = 1'b0;
    berr_stb_o  = 1'b0;
    done_stb_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_BEAT;
          ctr_clr_o = 1'b1;
        end
      end
      ST_BEAT: begin
        if (berr_i && halt_i) begin
          if (first_i) begin
            state_d     = ST_RETRY;
            retry_stb_o = 1'b1;
          end else begin
            state_d    = ST_HALT;
            halt_set_o = 1'b1;
          end
        end else if (berr_i) begin
          state_d    = ST_IDLE;
          berr_stb_o = 1'b1;
        end else if (ack_i) begin
          if (last_i) begin
            state_d    = ST_IDLE;
            done_stb_o = 1'b1;
          end else begin
            ctr_inc_o = 1'b1;
          end
        end
      end
      ST_RETRY: begin
        if (!halt_i) begin
          state_d   = ST_BEAT;
          ctr_clr_o = 1'b1;
        end
      end
      ST_HALT: begin
        if (!halt_i) begin
          state_d    = ST_IDLE;
          halt_clr_o = 1'b1;
          berr_stb_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_halt_only_later_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_set_o |-> !first_i);
  p_retry_only_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_stb_o |-> first_i);
endmodule

// File: rtl/burst_evt_regs.sv
module burst_evt_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retry_stb_i,
  input  logic halt_set_i,
  input  logic halt_clr_i,
  input  logic berr_stb_i,
  input  logic done_stb_i,
  output logic retry_o,
  output logic halted_o,
  output logic berr_req_o,
  output logic fill_done_o
);
  logic retry_q, halted_q, berr_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retry_q  <= 1'b0;
      halted_q <= 1'b0;
      berr_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      retry_q <= retry_stb_i;
      berr_q  <= berr_stb_i;
      done_q  <= done_stb_i;
      if (halt_set_i)      halted_q <= 1'b1;
      else if (halt_clr_i) halted_q <= 1'b0;
    end
  end

  assign retry_o     = retry_q;
  assign halted_o    = halted_q;
  assign berr_req_o  = berr_q;
  assign fill_done_o = done_q;

  p_no_berr_while_halted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> !berr_q);
endmodule

// File: rtl/burst_fill_ctrl.sv
module burst_fill_ctrl
  import burst_fill_pkg::*;
#(
  parameter int unsigned BEATS = 4,
  localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_start_i,
  input  logic          ack_i,
  input  logic          berr_i,
  input  logic          halt_i,
  output logic          burst_req_o,
  output logic          busy_o,
  output logic [BW-1:0] beat_o,
  output logic          fill_done_o,
  output logic          retry_o,
  output logic          halted_o,
  output logic          berr_req_o
);
  fill_state_e state;
  logic ctr_clr, ctr_inc, first, last;
  logic retry_stb, halt_set, halt_clr, berr_stb, done_stb;

  burst_beat_ctr #(.BEATS(BEATS)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctr_clr),
    .inc_i   (ctr_inc),
    .beat_o  (beat_o),
    .first_o (first),
    .last_o  (last)
  );

  burst_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (fill_start_i),
    .ack_i       (ack_i),
    .berr_i      (berr_i),
    .halt_i      (halt_i),
    .first_i     (first),
    .last_i      (last),
    .state_o     (state),
    .ctr_clr_o   (ctr_clr),
    .ctr_inc_o   (ctr_inc),
    .retry_stb_o (retry_stb),
    .halt_set_o  (halt_set),
    .halt_clr_o  (halt_clr),
    .berr_stb_o  (berr_stb),
    .done_stb_o  (done_stb)
  );

  burst_evt_regs i_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .retry_stb_i (retry_stb),
    .halt_set_i  (halt_set),
    .halt_clr_i  (halt_clr),
    .berr_stb_i  (berr_stb),
    .done_stb_i  (done_stb),
    .retry_o     (retry_o),
    .halted_o    (halted_o),
    .berr_req_o  (berr_req_o),
    .fill_done_o (fill_done_o)
  );

  assign burst_req_o = (state == ST_BEAT) && first;
  assign busy_o      = (state != ST_IDLE);

  p_retry_after_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retry_o) |-> $past(berr_i && halt_i && beat_o == '0));
  p_retry_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o);
  p_halted_no_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!burst_req_o && busy_o));
  p_release_berr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> (berr_req_o && !busy_o));
  p_berr_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_req_o |=> !berr_req_o);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done_o |-> !busy_o);
endmodule

// File: tb/test_burst_fill_ctrl.sv
module test_burst_fill_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, ack = 1'b0, berr = 1'b0, halt = 1'b0;
  logic burst_req, busy, fill_done, retry, halted, berr_req;
  logic [1:0] beat;
  int checks = 0;
  int errors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  burst_fill_ctrl i_burst_fill_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fill_start_i(start), .ack_i(ack),
    .berr_i(berr), .halt_i(halt), .burst_req_o(burst_req), .busy_o(busy),
    .beat_o(beat), .fill_done_o(fill_done), .retry_o(retry),
    .halted_o(halted), .berr_req_o(berr_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic begin_fill();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic finish_beats(input int from);
    for (int k = from; k < 4; k++) begin
      chk("R2", "beat", beat, k);
      chk("R2", "burst_req", burst_req, (k == 0));
      ack = 1'b1;
      step();
    end
    ack = 1'b0;
    chk("R2", "fill_done", fill_done, 1);
    chk("R2", "busy", busy, 0);
    step();
    chk("R2", "fill_done pulse", fill_done, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    step();
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "burst_req", burst_req, 0);
    chk("R1", "retry", retry, 0);
    chk("R1", "halted", halted, 0);
    chk("R1", "berr_req", berr_req, 0);
    chk("R1", "fill_done", fill_done, 0);
    chk("R1", "beat", beat, 0);
    rst_n = 1'b1;
    step();

    // R2 clean fill
    begin_fill();
    chk("R2", "busy", busy, 1);
    finish_beats(0);

    // Sweep: every beat x {lone error, error+halt} x halt hold length
    for (int b = 0; b < 4; b++) begin
      for (int mode = 0; mode < 4; mode++) begin
        int hold = mode;  // mode 0: lone error; 1..3: halt held for that many cycles
        begin_fill();
        for (int k = 0; k < b; k++) begin ack = 1'b1; step(); end
        ack = 1'b0;
        berr = 1'b1;
        halt = (hold > 0);
        step();
        berr = 1'b0;
        if (hold == 0) begin
          chk("R8", "berr_req", berr_req, 1);
          chk("R8", "retry", retry, 0);
          chk("R8", "halted", halted, 0);
          chk("R8", "busy", busy, 0);
          step();
          chk("R8", "berr_req pulse", berr_req, 0);
        end else if (b == 0) begin
          chk("R3", "retry", retry, 1);
          chk("R3", "burst_req", burst_req, 0);
          chk("R3", "busy", busy, 1);
          chk("R3", "berr_req", berr_req, 0);
          for (int h = 1; h < hold; h++) begin
            step();
            chk("R3", "retry pulse", retry, 0);
            chk("R3", "burst_req during halt", burst_req, 0);
          end
          halt = 1'b0;
          step();
          chk("R4", "restart burst_req", burst_req, 1);
          chk("R4", "restart beat", beat, 0);
          chk("R4", "berr_req", berr_req, 0);
          finish_beats(0);
        end else begin
          chk("R5", "retry", retry, 0);
          chk("R5", "halted", halted, 1);
          for (int h = 1; h < hold; h++) begin
            step();
            chk("R6", "halted held", halted, 1);
            chk("R6", "berr_req held off", berr_req, 0);
          end
          halt = 1'b0;
          step();
          chk("R7", "halted", halted, 0);
          chk("R7", "berr_req", berr_req, 1);
          chk("R7", "busy", busy, 0);
          step();
          chk("R7", "berr_req pulse", berr_req, 0);
        end
        halt = 1'b0;
        step();
      end
    end

    // R9: error and ack together on beat 1
    begin_fill();
    ack = 1'b1; step();
    berr = 1'b1; step();
    ack = 1'b0; berr = 1'b0;
    chk("R9", "berr_req", berr_req, 1);
    chk("R9", "fill_done", fill_done, 0);
    chk("R9", "busy", busy, 0);
    step();

    // R10: lone halt on beat 1, then halt with ack
    begin_fill();
    ack = 1'b1; step(); ack = 1'b0;
    halt = 1'b1;
    for (int h = 0; h < 3; h++) begin
      step();
      chk("R10", "beat", beat, 1);
      chk("R10", "halted", halted, 0);
      chk("R10", "retry", retry, 0);
      chk("R10", "busy", busy, 1);
    end
    ack = 1'b1; step(); ack = 1'b0; halt = 1'b0;
    chk("R10", "beat after ack", beat, 2);

    // R11: start request during burst
    start = 1'b1; step(); start = 1'b0;
    chk("R11", "beat", beat, 2);
    finish_beats(2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule